// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed running sum in two 32-bit halves, an upper half and a lower half. Each accepted operation multiplies two signed operands, sign-extends the product to 64 bits and adds it to the running sum. The new sum is written back to the two halves on the next clock edge.

There are two operation widths. The long form multiplies full 32-bit operands. The word form multiplies only the low 16 bits of each operand. When the saturation input is set, each width applies its own clamping rule. A word result outside the signed 32-bit range is replaced by a clamped 32-bit value, and the upper half is set to 1 to mark the overflow. A long result only has the upper bits of its high half forced, according to the sign of the sum.

Software-style access uses three inputs. A synchronous clear zeroes both halves. Two per-half write enables load each half directly. The halves are always visible on output ports. A one-cycle completion pulse is raised in the cycle in which a result appears.

Top module: `sat_mac_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both accumulator halves read zero and the completion pulse is low.
- R2: An accepted long operation (`op_sel`=0) adds the signed 32x32 product of `opnd_a` and `opnd_b` to the 64-bit value {`acc_hi`,`acc_lo`}. The result is visible on the first clock edge after the strobe. `op_done` is high for exactly that one cycle.
- R3: A word operation (`op_sel`=1) uses bits [15:0] of each operand as signed 16-bit values. Bits [31:16] of both operands have no effect on the result.
- R4: With `sat_en`=1, a long result whose 64-bit sum is negative has `acc_hi`[31:16] forced to all ones. A long result whose sum is non-negative has `acc_hi`[31:15] forced to zero. `acc_lo` always keeps the raw sum in both cases.
- R5: With `sat_en`=1, a word result below -2^31 gives `acc_hi`=1 and `acc_lo`=0x80000000. A sum of exactly -2^31 is not clamped.
- R6: With `sat_en`=1, a word result above 2^31-1 gives `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R7: With `sat_en`=1, a word result inside the signed 32-bit range is written unmodified to both halves. This includes both range limits.
- R8: With `sat_en`=0, both widths write the 64-bit sum wrapped modulo 2^64, with no clamping.
- R9: `acc_clr` zeroes both halves on the next edge. It takes priority over loads and over an operation in the same cycle, and no completion pulse follows.
- R10: `hi_we` and `lo_we` each load only their own half from its write-data port. In any cycle with a load or a clear, an operation strobe is discarded: the half that is not loaded keeps its value, and `op_done` stays low.
- R11: `sat_en` matters only in the strobe cycle. Changing it afterwards does not alter a result already written.
- R12: With no strobe, no load and no clear, both halves hold their value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_en | input | 1 | Saturation mode, sampled with the strobe |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_clr | input | 1 | Synchronous clear of both halves |
| hi_we | input | 1 | Load enable for the upper half |
| hi_wdata | input | 32 | Load data for the upper half |
| lo_we | input | 1 | Load enable for the lower half |
| lo_wdata | input | 32 | Load data for the lower half |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |
| op_done | output | 1 | One-cycle pulse when a result is written |

## Verification
The bench builds the block with its defaults: 32-bit operands, 16-bit word operands and a 16-bit forced field for long saturation. With these values the clamp limits sit at ±2^31. Accumulators can therefore be preloaded directly to one step from each limit, to the exact limit, and to the 64-bit wrap point. Each boundary is then reached with a single multiply, without long accumulation runs.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Operation width select
    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    // Default geometry shared by the modules
    localparam int unsigned OPND_W_DEF   = 32;
    localparam int unsigned HALF_W_DEF   = 16;
    localparam int unsigned SAT_TOP_DEF  = 16;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int unsigned OPND_W = 32,
    parameter int unsigned HALF_W = 16,
    localparam int unsigned ACC_W = 2 * OPND_W
) (
    input  mac_pkg::mac_op_e   op,
    input  logic [OPND_W-1:0]  a,
    input  logic [OPND_W-1:0]  b,
    output logic [ACC_W-1:0]   prod
);

    logic [ACC_W-1:0] a_long, b_long, a_word, b_word;
    logic [ACC_W-1:0] p_long, p_word;

    // Sign-extend both operand forms to full accumulator width; the low
    // ACC_W bits of an unsigned product of sign-extended values equal the
    // signed product.
    always_comb begin
        a_long = {{(ACC_W-OPND_W){a[OPND_W-1]}}, a};
        b_long = {{(ACC_W-OPND_W){b[OPND_W-1]}}, b};
        a_word = {{(ACC_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
        b_word = {{(ACC_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
        p_long = a_long * b_long;
        p_word = a_word * b_word;
        prod   = (op == mac_pkg::OP_WORD) ? p_word : p_long;
    end

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
    parameter int unsigned OPND_W  = 32,
    parameter int unsigned SAT_TOP = 16,
    localparam int unsigned ACC_W  = 2 * OPND_W,
    localparam int unsigned KEEP_W = OPND_W - SAT_TOP - 1
) (
    input  mac_pkg::mac_op_e   op,
    input  logic               sat,
    input  logic [ACC_W-1:0]   sum,
    output logic [OPND_W-1:0]  hi,
    output logic [OPND_W-1:0]  lo
);

    logic               neg;
    logic               fits;
    logic [OPND_W-1:0]  raw_hi, raw_lo;
    logic [OPND_W-1:0]  set_mask, keep_mask;

    always_comb begin
        raw_hi    = sum[ACC_W-1:OPND_W];
        raw_lo    = sum[OPND_W-1:0];
        neg       = sum[ACC_W-1];
        // In signed OPND_W range when every bit above the OPND_W-1 sign
        // position copies it.
        fits      = (sum[ACC_W-1:OPND_W-1] == '0) || (sum[ACC_W-1:OPND_W-1] == '1);
        set_mask  = {{SAT_TOP{1'b1}}, {(OPND_W-SAT_TOP){1'b0}}};
        keep_mask = {{(OPND_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
        hi        = raw_hi;
        lo        = raw_lo;
        if (sat) begin
            if (op == mac_pkg::OP_LONG) begin
                hi = neg ? (raw_hi | set_mask) : (raw_hi & keep_mask);
            end else if (!fits) begin
                hi = {{(OPND_W-1){1'b0}}, 1'b1};
                lo = neg ? {1'b1, {(OPND_W-1){1'b0}}} : {1'b0, {(OPND_W-1){1'b1}}};
            end
        end
    end

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
    parameter int unsigned OPND_W  = mac_pkg::OPND_W_DEF,
    parameter int unsigned HALF_W  = mac_pkg::HALF_W_DEF,
    parameter int unsigned SAT_TOP = mac_pkg::SAT_TOP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sel,
    input  logic              sat_en,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              acc_clr,
    input  logic              hi_we,
    input  logic [OPND_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [OPND_W-1:0] lo_wdata,
    output logic [OPND_W-1:0] acc_hi,
    output logic [OPND_W-1:0] acc_lo,
    output logic              op_done
);

    localparam int unsigned ACC_W = 2 * OPND_W;

    typedef struct packed {
        logic [OPND_W-1:0] hi;
        logic [OPND_W-1:0] lo;
        logic              done;
    } mac_state_t;

    mac_state_t        st_d, st_q;
    mac_pkg::mac_op_e  op_e;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic [OPND_W-1:0] res_hi, res_lo;
    logic              accept;

    assign op_e = mac_pkg::mac_op_e'(op_sel);

    mac_product #(
        .OPND_W (OPND_W),
        .HALF_W (HALF_W)
    ) product_i (
        .op   (op_e),
        .a    (opnd_a),
        .b    (opnd_b),
        .prod (prod)
    );

    assign sum = {st_q.hi, st_q.lo} + prod;

    mac_saturate #(
        .OPND_W  (OPND_W),
        .SAT_TOP (SAT_TOP)
    ) saturate_i (
        .op  (op_e),
        .sat (sat_en),
        .sum (sum),
        .hi  (res_hi),
        .lo  (res_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = op_valid && !acc_clr && !hi_we && !lo_we;
        if (acc_clr) begin
            st_d.hi = '0;
            st_d.lo = '0;
        end else if (hi_we || lo_we) begin
            if (hi_we) st_d.hi = hi_wdata;
            if (lo_we) st_d.lo = lo_wdata;
        end else if (accept) begin
            st_d.hi   = res_hi;
            st_d.lo   = res_lo;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_hi  = st_q.hi;
    assign acc_lo  = st_q.lo;
    assign op_done = st_q.done;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_clr && !hi_we && !lo_we) |=> op_done);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_done);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0) && (acc_lo == '0) && !op_done);

    // R10
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !acc_clr) |=> (acc_hi == $past(hi_wdata)) && !op_done);

    // R10
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !acc_clr) |=> (acc_lo == $past(lo_wdata)) && !op_done);

    // R4
    long_sat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_clr && !hi_we && !lo_we && sat_en && !op_sel) |=>
        ((acc_hi[OPND_W-1 -: SAT_TOP] == '1) || (acc_hi[OPND_W-1 -: SAT_TOP+1] == '0)));

    // R5
    word_sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_clr && !hi_we && !lo_we && sat_en && op_sel) |=>
        ((acc_hi == {{(OPND_W-1){1'b0}}, 1'b1}) || (acc_hi == {OPND_W{acc_lo[OPND_W-1]}})));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !acc_clr && !hi_we && !lo_we) |=> ($stable(acc_hi) && $stable(acc_lo)));

endmodule

// File: tb/sat_mac_unit_tb.sv
`timescale 1ns/1ps
module sat_mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_sel = 1'b0, sat_en = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        acc_clr = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
    logic [31:0] hi_wdata = '0, lo_wdata = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        op_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sat_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_clr(acc_clr),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .op_done(op_done)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        op;
        logic        sat;
        logic [31:0] hi0;
        logic [31:0] lo0;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] eh;
        logic [31:0] el;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        // R2 long: 3 * -5
        '{4'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'd3, 32'hFFFFFFFB, 32'hFFFFFFFF, 32'hFFFFFFF1},
        // R2 carry from low into high half
        '{4'd2, 1'b0, 1'b0, 32'h0, 32'hFFFFFFFF, 32'd2, 32'd1, 32'h1, 32'h1},
        // R8 long wrap past max positive
        '{4'd8, 1'b0, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'd1, 32'd1, 32'h80000000, 32'h0},
        // R8 word past 2^31-1 without clamping
        '{4'd8, 1'b1, 1'b0, 32'h0, 32'h7FFFFFFF, 32'h7FFF, 32'h7FFF, 32'h0, 32'hBFFF0000},
        // R3 word ignores upper operand bits: 2 * -3
        '{4'd3, 1'b1, 1'b0, 32'h0, 32'h0, 32'hABCD0002, 32'h1234FFFD, 32'hFFFFFFFF, 32'hFFFFFFFA},
        // R7 word saturated, result in range
        '{4'd7, 1'b1, 1'b1, 32'h0, 32'd10, 32'hFFFF8000, 32'd2, 32'hFFFFFFFF, 32'hFFFF000A},
        // R6 word clamp high
        '{4'd6, 1'b1, 1'b1, 32'h0, 32'h7FFFFFFF, 32'h7FFF, 32'h7FFF, 32'h1, 32'h7FFFFFFF},
        // R5 word clamp low
        '{4'd5, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1, 32'h0000FFFF, 32'h1, 32'h80000000},
        // R4 long saturated, negative sum
        '{4'd4, 1'b0, 1'b1, 32'h80001234, 32'h0, 32'd0, 32'd0, 32'hFFFF1234, 32'h0},
        // R4 long saturated, positive sum
        '{4'd4, 1'b0, 1'b1, 32'h7FFFFFFF, 32'h12345678, 32'd0, 32'd5, 32'h00007FFF, 32'h12345678},
        // R4 long saturated, small positive 2^32
        '{4'd4, 1'b0, 1'b1, 32'h0, 32'h0, 32'h10000, 32'h10000, 32'h1, 32'h0},
        // R7 exact upper limit not clamped
        '{4'd7, 1'b1, 1'b1, 32'h0, 32'h7FFFFFFE, 32'd1, 32'd1, 32'h0, 32'h7FFFFFFF},
        // R5 exact lower limit not clamped
        '{4'd5, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000001, 32'd1, 32'h0000FFFF, 32'hFFFFFFFF, 32'h80000000},
        // R8 long -2^31 * -2^31
        '{4'd8, 1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_both(input logic [31:0] h, input logic [31:0] l);
        hi_we = 1'b1; lo_we = 1'b1; hi_wdata = h; lo_wdata = l;
        @(posedge clk); #1;
        hi_we = 1'b0; lo_we = 1'b0;
    endtask

    task automatic run_op(input logic op, input logic sat, input logic [31:0] a, input logic [31:0] b);
        op_valid = 1'b1; op_sel = op; sat_en = sat; opnd_a = a; opnd_b = b;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 state during reset
        chk("R1", "hi in reset", acc_hi, 32'h0);
        chk("R1", "lo in reset", acc_lo, 32'h0);
        chk("R1", "done in reset", {31'b0, op_done}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "hi after reset", acc_hi, 32'h0);
        chk("R1", "done after reset", {31'b0, op_done}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", TBL[i].req, i);
            load_both(TBL[i].hi0, TBL[i].lo0);
            run_op(TBL[i].op, TBL[i].sat, TBL[i].a, TBL[i].b);
            chk(tag, "hi", acc_hi, TBL[i].eh);
            chk(tag, "lo", acc_lo, TBL[i].el);
            chk(tag, "done", {31'b0, op_done}, 32'h1);
            sat_en = 1'b0;
            @(posedge clk); #1;
            // R2 pulse lasts one cycle
            chk("R2", "done falls", {31'b0, op_done}, 32'h0);
        end

        // R11 saturation changed after the strobe
        load_both(32'h0, 32'h7FFFFFFF);
        run_op(1'b1, 1'b1, 32'h7FFF, 32'h7FFF);
        sat_en = 1'b0;
        @(posedge clk); #1;
        chk("R11", "hi kept", acc_hi, 32'h1);
        chk("R11", "lo kept", acc_lo, 32'h7FFFFFFF);

        // R12 idle with moving operands
        load_both(32'h13579BDF, 32'h2468ACE0);
        opnd_a = 32'h7FFFFFFF; opnd_b = 32'h7FFFFFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "hi hold", acc_hi, 32'h13579BDF);
        chk("R12", "lo hold", acc_lo, 32'h2468ACE0);

        // R10 high load beats an operation; low half untouched
        load_both(32'h11111111, 32'h22222222);
        hi_we = 1'b1; hi_wdata = 32'hAAAA5555;
        op_valid = 1'b1; op_sel = 1'b0; sat_en = 1'b0; opnd_a = 32'd1; opnd_b = 32'd1;
        @(posedge clk); #1;
        hi_we = 1'b0; op_valid = 1'b0;
        chk("R10", "hi loaded", acc_hi, 32'hAAAA5555);
        chk("R10", "lo untouched", acc_lo, 32'h22222222);
        chk("R10", "no done", {31'b0, op_done}, 32'h0);
        lo_we = 1'b1; lo_wdata = 32'h00000033;
        @(posedge clk); #1;
        lo_we = 1'b0;
        chk("R10", "hi kept on lo load", acc_hi, 32'hAAAA5555);
        chk("R10", "lo loaded", acc_lo, 32'h00000033);

        // R9 clear beats load and operation
        acc_clr = 1'b1; hi_we = 1'b1; hi_wdata = 32'hDEADBEEF;
        op_valid = 1'b1; opnd_a = 32'd9; opnd_b = 32'd9;
        @(posedge clk); #1;
        acc_clr = 1'b0; hi_we = 1'b0; op_valid = 1'b0;
        chk("R9", "hi cleared", acc_hi, 32'h0);
        chk("R9", "lo cleared", acc_lo, 32'h0);
        chk("R9", "no done", {31'b0, op_done}, 32'h0);

        // R2 accumulation over two back-to-back operations
        op_valid = 1'b1; op_sel = 1'b0; opnd_a = 32'd7; opnd_b = 32'd6;
        @(posedge clk); #1;
        opnd_a = 32'hFFFFFFFF; opnd_b = 32'd50;
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk("R2", "two ops hi", acc_hi, 32'hFFFFFFFF);
        chk("R2", "two ops lo", acc_lo, 32'hFFFFFFF8);
        chk("R2", "two ops done", {31'b0, op_done}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule